// File: doc/BRIEF.md
# Single-Block Read Receive Path

This block takes in one data block that a card sends on its data line after the host issues a read command carrying a transfer-start request. It waits for the start bit and shifts the following bits into 32-bit words. Each finished word is placed in a receive data register, and a ready flag is raised. The host clears the flag by reading the word. If a new word completes while the previous one is still unread, an overrun flag records it. After the payload, the block takes in the 16-bit CRC and the end bit. It then reports block end, and it reports a data CRC error when either of these does not match.

The command register write arms the path. The transfer field must request a start, the direction bit must select a read, and the type field must select a single block. The block length comes from the upper half of the mode register. A separate one-cycle strobe marks each valid bit on the data line, so the block does not depend on the card clock divider.

Top module: `blkrd_rx`

## Requirements
- R1: A command write arms the path only when transfer field cmd_word[17:16] is 1, bit 18 is 1 (read) and type field [20:19] is 0 (single block). st_busy is high on the cycle after such a write. Any other command write leaves st_busy low.
- R2: The block length is mode_word[31:16] with its two low bits taken as zero. The payload holds that many bytes, and the value is captured when the path is armed.
- R3: While armed, data bits equal to 1 before the first 0 (the start bit) are ignored.
- R4: Payload bytes arrive MSB first. The first byte of each group of four lands in rx_word[31:24]. rx_word updates and st_rx_ready rises on the cycle after the strobe of the word's last bit.
- R5: A rd_strobe clears st_rx_ready on the next cycle. If rd_strobe coincides with the completion of a new word, st_rx_ready stays high.
- R6: When a word completes while st_rx_ready is high and no rd_strobe is present, st_overrun is set and rx_word takes the new word. st_overrun stays set until the next arm.
- R7: A CRC16 with polynomial 0x1021 and zero initial value is computed over the payload bits. The 16 bits after the payload are the received CRC, MSB first. A mismatch, or an end bit of 0, sets st_crc_err.
- R8: On the strobe of the end bit, st_block_end rises and st_busy falls on the same cycle.
- R9: A command write with transfer field 2 (stop) while busy drops st_busy on the next cycle. Later data bits then produce no word and no block end.
- R10: After reset, all status outputs and rx_word are zero.
- R11: Arming clears st_rx_ready, st_overrun, st_block_end and st_crc_err.
- R12: With an effective length of zero, the CRC bits follow the start bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | 32 | Command register write value |
| mode_word | input | 32 | Current mode register value (length in [31:16]) |
| bit_en | input | 1 | One-cycle strobe marking a valid data-line bit |
| dat_in | input | 1 | Data line level |
| rd_strobe | input | 1 | Host read of the receive data register |
| rx_word | output | 32 | Receive data register |
| st_rx_ready | output | 1 | Word available |
| st_overrun | output | 1 | Word lost to overrun |
| st_block_end | output | 1 | Block fully received |
| st_crc_err | output | 1 | Data CRC or end-bit error |
| st_busy | output | 1 | Data transfer in progress |

## Verification
The bench uses the default parameters: 32-bit words, a 16-bit length field and a 16-bit CRC with polynomial 0x1021. Lengths of 0, 8 and 11 bytes keep each frame under a hundred bit strobes. These lengths still reach the zero-payload path, the dropped low length bits and the last-word transition into the CRC field. With two-word blocks, the bench can leave a word unread, or time a read to land on the same edge as the next word. This covers overrun and the read/complete race.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

  localparam int REG_W     = 32;
  localparam int XFER_LSB  = 16;
  localparam int DIR_BIT   = 18;
  localparam int TYPE_LSB  = 19;
  localparam int LEN_LSB   = 16;

  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_START = 2'd1,
    XF_STOP  = 2'd2,
    XF_RSVD  = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    TT_SINGLE = 2'd0,
    TT_MULTI  = 2'd1,
    TT_STREAM = 2'd2,
    TT_RSVD   = 2'd3
  } xtype_e;

  typedef enum logic [2:0] {
    FR_IDLE = 3'd0,
    FR_HUNT = 3'd1,
    FR_DATA = 3'd2,
    FR_CRC  = 3'd3,
    FR_TAIL = 3'd4
  } fr_state_e;

  typedef struct packed {
    logic arm;
    logic stop;
  } cmd_dec_t;

  // Split a command word into arm / stop requests.
  function automatic cmd_dec_t decode_cmd(input logic [REG_W-1:0] w);
    cmd_dec_t d;
    xfer_e    xf;
    xtype_e   tt;
    xf     = xfer_e'(w[XFER_LSB +: 2]);
    tt     = xtype_e'(w[TYPE_LSB +: 2]);
    d.arm  = (xf == XF_START) && w[DIR_BIT] && (tt == TT_SINGLE);
    d.stop = (xf == XF_STOP);
    return d;
  endfunction

  // Byte length to whole 32-bit words (two low bits dropped).
  function automatic logic [REG_W-1:0] len_to_words(input logic [REG_W-1:0] len);
    return len >> 2;
  endfunction

endpackage

// File: rtl/blkrd_cmd_decode.sv
module blkrd_cmd_decode
  import blkrd_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int WC_W = LEN_W - 2
) (
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_word,
  input  logic [REG_W-1:0] mode_word,
  output logic             arm,
  output logic             stop,
  output logic [WC_W-1:0]  nwords
);

  cmd_dec_t         dec;
  logic [REG_W-1:0] len_ext;
  logic [REG_W-1:0] words_ext;

  always_comb begin
    dec       = decode_cmd(cmd_word);
    arm       = cmd_wr && dec.arm;
    stop      = cmd_wr && dec.stop;
    len_ext   = REG_W'(mode_word[LEN_LSB +: LEN_W]);
    words_ext = len_to_words(len_ext);
    nwords    = words_ext[WC_W-1:0];
  end

endmodule

// File: rtl/blkrd_crc.sv
module blkrd_crc #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] nxt;
  logic             fb;

  always_comb begin
    fb  = crc[CRC_W-1] ^ din;
    nxt = {crc[CRC_W-2:0], 1'b0};
    for (int i = 0; i < CRC_W; i++) begin
      if (fb && POLY[i]) nxt[i] = ~nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= nxt;
  end

endmodule

// File: rtl/blkrd_frame.sv
module blkrd_frame
  import blkrd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int CRC_W  = 16,
  localparam int WC_W  = LEN_W - 2,
  localparam int BC_W  = $clog2(DATA_W),
  localparam int CC_W  = $clog2(CRC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stop,
  input  logic [WC_W-1:0]   nwords,
  input  logic              bit_en,
  input  logic              dat,
  input  logic [CRC_W-1:0]  crc_val,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              word_done,
  output logic [DATA_W-1:0] word_val,
  output logic              block_done,
  output logic              crc_bad
);

  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);
  localparam logic [CC_W-1:0] CC_LAST = CC_W'(CRC_W - 1);

  fr_state_e         state;
  logic [BC_W-1:0]   bit_cnt;
  logic [WC_W-1:0]   word_cnt;
  logic [WC_W-1:0]   nwords_q;
  logic [CC_W-1:0]   crc_cnt;
  logic [DATA_W-1:0] shreg;
  logic [CRC_W-1:0]  rcrc;
  logic              step;

  always_comb begin
    step       = bit_en && !arm && !stop;
    word_val   = {shreg[DATA_W-2:0], dat};
    crc_clr    = arm;
    crc_en     = step && (state == FR_DATA);
    word_done  = crc_en && (bit_cnt == BC_LAST);
    block_done = step && (state == FR_TAIL);
    crc_bad    = (rcrc != crc_val) || !dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FR_IDLE;
      bit_cnt  <= '0;
      word_cnt <= '0;
      nwords_q <= '0;
      crc_cnt  <= '0;
      shreg    <= '0;
      rcrc     <= '0;
    end else if (arm) begin
      state    <= FR_HUNT;
      nwords_q <= nwords;
      bit_cnt  <= '0;
      word_cnt <= '0;
      crc_cnt  <= '0;
    end else if (stop) begin
      state <= FR_IDLE;
    end else if (bit_en) begin
      case (state)
        FR_HUNT: begin
          if (!dat) state <= (nwords_q == '0) ? FR_CRC : FR_DATA;
        end
        FR_DATA: begin
          shreg   <= word_val;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_LAST) begin
            word_cnt <= word_cnt + 1'b1;
            if (word_cnt == nwords_q - WC_W'(1)) state <= FR_CRC;
          end
        end
        FR_CRC: begin
          rcrc    <= {rcrc[CRC_W-2:0], dat};
          crc_cnt <= crc_cnt + 1'b1;
          if (crc_cnt == CC_LAST) state <= FR_TAIL;
        end
        FR_TAIL: state <= FR_IDLE;
        default: state <= FR_IDLE;
      endcase
    end
  end

  AST_HUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_HUNT && bit_en && dat && !arm && !stop) |=> (state == FR_HUNT)); // R3

  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_DATA) |-> (word_cnt < nwords_q)); // R2

  AST_EMPTY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_HUNT && step && !dat && nwords_q == '0) |=> (state == FR_CRC)); // R12

endmodule

// File: rtl/blkrd_status.sv
module blkrd_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              stop,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word_val,
  input  logic              block_done,
  input  logic              crc_bad,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_word,
  output logic              st_rx_ready,
  output logic              st_overrun,
  output logic              st_block_end,
  output logic              st_crc_err,
  output logic              st_busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word      <= '0;
      st_rx_ready  <= 1'b0;
      st_overrun   <= 1'b0;
      st_block_end <= 1'b0;
      st_crc_err   <= 1'b0;
      st_busy      <= 1'b0;
    end else if (arm) begin
      st_rx_ready  <= 1'b0;
      st_overrun   <= 1'b0;
      st_block_end <= 1'b0;
      st_crc_err   <= 1'b0;
      st_busy      <= 1'b1;
    end else begin
      if (block_done || stop) st_busy <= 1'b0;
      if (word_done) begin
        rx_word     <= word_val;
        st_rx_ready <= 1'b1;
        if (st_rx_ready && !rd_strobe) st_overrun <= 1'b1;
      end else if (rd_strobe) begin
        st_rx_ready <= 1'b0;
      end
      if (block_done) begin
        st_block_end <= 1'b1;
        if (crc_bad) st_crc_err <= 1'b1;
      end
    end
  end

  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (st_busy && !st_rx_ready && !st_overrun && !st_block_end && !st_crc_err)); // R11

  AST_RDY_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rx_ready) |-> $past(word_done)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !word_done && !arm) |=> !st_rx_ready); // R5

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_overrun) |-> $past(word_done && st_rx_ready && !rd_strobe)); // R6

  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_block_end) |-> $fell(st_busy)); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !arm) |=> !st_busy); // R9

endmodule

// File: rtl/blkrd_rx.sv
module blkrd_rx
  import blkrd_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          LEN_W  = 16,
  parameter int          CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h1021,
  localparam int         WC_W   = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       mode_word,
  input  logic              bit_en,
  input  logic              dat_in,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_word,
  output logic              st_rx_ready,
  output logic              st_overrun,
  output logic              st_block_end,
  output logic              st_crc_err,
  output logic              st_busy
);

  logic              arm;
  logic              stop;
  logic [WC_W-1:0]   nwords;
  logic              crc_clr;
  logic              crc_en;
  logic [CRC_W-1:0]  crc_val;
  logic              word_done;
  logic [DATA_W-1:0] word_val;
  logic              block_done;
  logic              crc_bad;

  blkrd_cmd_decode #(.LEN_W(LEN_W)) u_dec (
    .cmd_wr    (cmd_wr),
    .cmd_word  (cmd_word),
    .mode_word (mode_word),
    .arm       (arm),
    .stop      (stop),
    .nwords    (nwords)
  );

  blkrd_crc #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (dat_in),
    .crc   (crc_val)
  );

  blkrd_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CRC_W(CRC_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .stop       (stop),
    .nwords     (nwords),
    .bit_en     (bit_en),
    .dat        (dat_in),
    .crc_val    (crc_val),
    .crc_clr    (crc_clr),
    .crc_en     (crc_en),
    .word_done  (word_done),
    .word_val   (word_val),
    .block_done (block_done),
    .crc_bad    (crc_bad)
  );

  blkrd_status #(.DATA_W(DATA_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .stop         (stop),
    .word_done    (word_done),
    .word_val     (word_val),
    .block_done   (block_done),
    .crc_bad      (crc_bad),
    .rd_strobe    (rd_strobe),
    .rx_word      (rx_word),
    .st_rx_ready  (st_rx_ready),
    .st_overrun   (st_overrun),
    .st_block_end (st_block_end),
    .st_crc_err   (st_crc_err),
    .st_busy      (st_busy)
  );

  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> st_busy); // R9

endmodule

// File: tb/test_blkrd_rx.sv
module test_blkrd_rx;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;
  localparam logic [31:0] CMD_READ = 32'h0005_0051;
  localparam logic [31:0] CMD_STOP = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [31:0] mode_word = '0;
  logic        bit_en = 1'b0;
  logic        dat_in = 1'b1;
  logic        rd_strobe = 1'b0;
  logic [31:0] rx_word;
  logic        st_rx_ready, st_overrun, st_block_end, st_crc_err, st_busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] pay [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  blkrd_rx i_blkrd_rx (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .mode_word(mode_word), .bit_en(bit_en), .dat_in(dat_in),
    .rd_strobe(rd_strobe), .rx_word(rx_word), .st_rx_ready(st_rx_ready),
    .st_overrun(st_overrun), .st_block_end(st_block_end),
    .st_crc_err(st_crc_err), .st_busy(st_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // x^16 + x^12 + x^5 + 1, bit-serial, written per tap
  function automatic logic [15:0] crc_ref(input int nbytes);
    logic [15:0] c = '0;
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 7; k >= 0; k--) begin
        logic fb;
        fb = c[15] ^ pay[i][k];
        c = c << 1;
        if (fb) begin
          c[0] = ~c[0]; c[5] = ~c[5]; c[12] = ~c[12];
        end
      end
    end
    return c;
  endfunction

  task automatic write_cmd(input logic [31:0] w);
    cmd_word = w; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic send_bit(input logic b, input logic rd);
    bit_en = 1'b1; dat_in = b; rd_strobe = rd;
    @(negedge clk);
    bit_en = 1'b0; rd_strobe = 1'b0; dat_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input int idx, input logic rd_last);
    for (int k = 7; k >= 0; k--) send_bit(pay[idx][k], (k == 0) ? rd_last : 1'b0);
  endtask

  task automatic send_crc(input logic [15:0] c);
    for (int k = 15; k >= 0; k--) send_bit(c[k], 1'b0);
  endtask

  task automatic read_word();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input int last);
    return {pay[last-3], pay[last-2], pay[last-1], pay[last]};
  endfunction

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 16; i++) pay[i] = 8'(seed * (i + 3) + i * 8'h1d);
  endtask

  task automatic t_reset();
    chk("R10 rx_word", rx_word, 32'h0);
    chk("R10 flags", {st_rx_ready, st_overrun, st_block_end, st_crc_err, st_busy}, 32'h0);
  endtask

  task automatic t_ignored();
    mode_word = 32'h0008_0000;
    write_cmd(32'h0001_0051);           // start, write direction
    chk("R1 write dir ignored", st_busy, 1'b0);
    write_cmd(32'h000D_0051);           // start, read, multi-block
    chk("R1 multi ignored", st_busy, 1'b0);
    write_cmd(32'h0004_0051);           // no transfer
    chk("R1 no-xfer ignored", st_busy, 1'b0);
  endtask

  task automatic t_good_block();
    fill(8'h37);
    mode_word = 32'h0008_00FF;
    write_cmd(CMD_READ);
    chk("R1 armed", st_busy, 1'b1);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    chk("R3 idle ones give nothing", st_rx_ready, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      send_byte(i, 1'b0);
      if (i % 4 == 3) begin
        chk("R4 ready after word", st_rx_ready, 1'b1);
        chk("R4 word packing", rx_word, exp_word(i));
        read_word();
        chk("R5 read clears ready", st_rx_ready, 1'b0);
      end
    end
    send_crc(crc_ref(8));
    chk("R8 no end before end bit", st_block_end, 1'b0);
    send_bit(1'b1, 1'b0);
    chk("R8 block end", st_block_end, 1'b1);
    chk("R8 busy dropped", st_busy, 1'b0);
    chk("R7 good crc", st_crc_err, 1'b0);
    chk("R6 no overrun", st_overrun, 1'b0);
  endtask

  task automatic t_overrun();
    fill(8'hA5);
    mode_word = 32'h0008_0000;
    write_cmd(CMD_READ);
    chk("R11 flags cleared on arm", {st_block_end, st_crc_err, st_overrun, st_rx_ready}, 32'h0);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(i, 1'b0);
    chk("R6 overrun set", st_overrun, 1'b1);
    chk("R6 newer word kept", rx_word, exp_word(7));
    read_word();
    send_crc(crc_ref(8));
    send_bit(1'b1, 1'b0);
    chk("R6 overrun sticky", st_overrun, 1'b1);
    write_cmd(CMD_READ);
    chk("R11 overrun cleared", st_overrun, 1'b0);
    chk("R11 block end cleared", st_block_end, 1'b0);
    write_cmd(CMD_STOP);
  endtask

  task automatic t_race();
    fill(8'h5C);
    mode_word = 32'h0008_0000;
    write_cmd(CMD_READ);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(i, i == 7);
    chk("R5 ready held on race", st_rx_ready, 1'b1);
    chk("R5 no overrun on race", st_overrun, 1'b0);
    chk("R5 race word", rx_word, exp_word(7));
    read_word();
    send_crc(crc_ref(8));
    send_bit(1'b1, 1'b0);
  endtask

  task automatic t_bad_crc();
    fill(8'h11);
    mode_word = 32'h0008_0000;
    write_cmd(CMD_READ);
    chk("R11 crc err cleared", st_crc_err, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(i, i % 4 == 3);
    send_crc(crc_ref(8) ^ 16'h0100);
    send_bit(1'b1, 1'b0);
    chk("R7 crc mismatch flagged", st_crc_err, 1'b1);
    chk("R8 end despite crc error", st_block_end, 1'b1);
    write_cmd(CMD_READ);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(i, i % 4 == 3);
    send_crc(crc_ref(8));
    send_bit(1'b0, 1'b0);
    chk("R7 bad end bit flagged", st_crc_err, 1'b1);
  endtask

  task automatic t_trunc();
    fill(8'h6B);
    mode_word = 32'h000B_0000;          // 11 -> 8 bytes
    write_cmd(CMD_READ);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(i, i % 4 == 3);
    send_crc(crc_ref(8));
    send_bit(1'b1, 1'b0);
    chk("R2 length low bits dropped", st_block_end, 1'b1);
    chk("R2 crc at truncated length", st_crc_err, 1'b0);
  endtask

  task automatic t_empty();
    mode_word = 32'h0003_0000;          // 3 -> 0 bytes
    write_cmd(CMD_READ);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_crc(16'h0000);
    send_bit(1'b1, 1'b0);
    chk("R12 empty block end", st_block_end, 1'b1);
    chk("R12 empty crc ok", st_crc_err, 1'b0);
    chk("R12 no word", st_rx_ready, 1'b0);
  endtask

  task automatic t_stop();
    mode_word = 32'h0008_0000;
    write_cmd(CMD_READ);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0);
    write_cmd(CMD_STOP);
    chk("R9 stop drops busy", st_busy, 1'b0);
    for (int i = 0; i < 120; i++) send_bit(i[1], 1'b0);
    chk("R9 no word after stop", st_rx_ready, 1'b0);
    chk("R9 no block end after stop", st_block_end, 1'b0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored();
    t_good_block();
    t_overrun();
    t_race();
    t_bad_crc();
    t_trunc();
    t_empty();
    t_stop();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule